// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight interrupt request lines, keeps a pending and an in-service record per level, and raises a single request toward the processor whenever an unmasked pending level outranks everything currently being serviced. Level 0 ranks highest and level 7 lowest. When the processor acknowledges, the controller answers with an 8-bit vector: a programmed base in the upper five bits joined with the winning level number in the lower three.

Several units can be chained. A unit strapped as master takes the processor acknowledge directly. If the winning level is one that a slave unit feeds, the master does not answer with a vector. Instead it names that level on a 3-bit cascade bus for one cycle. A unit strapped as slave ignores the processor acknowledge and responds only when the cascade bus carries its own programmed identity. In that case it answers with its own vector one cycle later. One master and eight slaves give 64 requests.

Configuration comes over a byte-wide write port with a select bit. With select low, the byte is a command: it either starts the initialization sequence or ends the highest-ranked service. With select high, the byte is data: the base vector and the cascade setting during initialization, and the mask after that.

Top module: `pic_cascade_top`

## Requirements
- R1: After reset, int_out, vec_valid and cas_valid_out are 0, and all eight levels are masked, so a request edge on any line does not raise int_out.
- R2: A write with wr_sel=0 and wr_data bit 4 set starts initialization. It clears all pending and in-service bits and the mask. The next two wr_sel=1 writes load the base from bits 7:3 and then the cascade setting. int_out stays 0 until the second of those writes, and requests whose edges arrive during the sequence are kept.
- R3: A rising edge on irq_in[n] marks level n pending. int_out is 1 exactly when some unmasked pending level exists whose number is lower than every in-service level. Level 0 has the highest priority.
- R4: After initialization, a wr_sel=1 write loads the mask, where bit n set blocks level n. A masked level stays pending and raises int_out once it is unmasked.
- R5: On a master, inta=1 in a cycle where int_out=1 takes the winning level. In the next cycle vec_valid=1 for one cycle with vec_out = {base, level}. The level's in-service bit is set and its pending bit is cleared.
- R6: On a master, when the winning level has its bit set in the cascade setting (a bitmap of slave-fed inputs), acknowledge puts the level on cas_out with cas_valid_out=1 for one cycle instead of a vector. The in-service and pending updates are as in R5.
- R7: A slave (is_master=0) ignores inta. When cas_valid_in=1 and cas_in equals bits 2:0 of its cascade setting while its int_out=1, it acts as in R5 and presents its vector in the next cycle. Any other identity is ignored.
- R8: A write with wr_sel=0, bit 4 clear and bit 5 set clears the lowest-numbered in-service bit. A command byte with both bits 4 and 5 clear has no effect.
- R9: An acknowledge while int_out=0 produces no vector, no cascade output and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| is_master | input | 1 | 1 = master, 0 = slave |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_sel | input | 1 | 0 = command byte, 1 = data byte |
| wr_data | input | 8 | Write byte |
| irq_in | input | 8 | Rising-edge interrupt requests, level 0 highest |
| inta | input | 1 | Processor acknowledge strobe (master only) |
| cas_in | input | 3 | Cascade identity from master (slave only) |
| cas_valid_in | input | 1 | Cascade identity valid |
| int_out | output | 1 | Interrupt request toward processor or master |
| vec_out | output | 8 | Vector: base in bits 7:3, level in bits 2:0 |
| vec_valid | output | 1 | vec_out valid, one cycle |
| cas_out | output | 3 | Slave-fed level being serviced (master) |
| cas_valid_out | output | 1 | cas_out valid, one cycle |

## Verification
The bench chains a master and a slave, with the slave's request feeding master input 3. It checks nested service: a lower-numbered request must preempt an active level, while a higher-numbered one must wait until end-of-interrupt. A design that compares against the wrong in-service level would either lock out the preempting level or let the lower-ranked one through. Several cases target state that should survive or be dropped: requests arriving during initialization, masked requests that must remain pending, and command bytes that must be ignored. A design that dropped pending bits or decoded commands too loosely would lose an interrupt or clear service early. The cascade handshake is checked with both the matching identity and a foreign one, and with a stray processor acknowledge at the slave. A slave that answers the wrong identity would drive a second vector onto the bus.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Command byte field positions (wr_sel = 0)
  localparam int CMD_INIT_BIT = 4;
  localparam int CMD_EOI_BIT  = 5;

  typedef enum logic [1:0] {
    CFG_RUN  = 2'd0,
    CFG_BASE = 2'd1,
    CFG_CASC = 2'd2
  } cfg_state_e;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int VEC_W   = 8,
  localparam int LVL_W  = $clog2(NUM_LVL),
  localparam int BASE_W = VEC_W - LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [VEC_W-1:0]   wr_data,
  output logic [BASE_W-1:0]  base,
  output logic [NUM_LVL-1:0] casc_cfg,
  output logic [NUM_LVL-1:0] mask,
  output logic               ready,
  output logic               init_clr,
  output logic               eoi
);
  cfg_state_e                state_q, state_d;
  logic [BASE_W-1:0]         base_d;
  logic [NUM_LVL-1:0]        casc_d, mask_d;
  logic                      cmd_wr, data_wr;

  assign cmd_wr   = wr_en && !wr_sel;
  assign data_wr  = wr_en && wr_sel;
  assign init_clr = cmd_wr && wr_data[CMD_INIT_BIT];
  assign eoi      = cmd_wr && !wr_data[CMD_INIT_BIT] && wr_data[CMD_EOI_BIT]
                    && (state_q == CFG_RUN);
  assign ready    = (state_q == CFG_RUN);

  always_comb begin
    state_d = state_q;
    base_d  = base;
    casc_d  = casc_cfg;
    mask_d  = mask;
    if (init_clr) begin
      state_d = CFG_BASE;
      mask_d  = '0;
    end else if (data_wr) begin
      unique case (state_q)
        CFG_BASE: begin
          base_d  = wr_data[VEC_W-1:LVL_W];
          state_d = CFG_CASC;
        end
        CFG_CASC: begin
          casc_d  = wr_data[NUM_LVL-1:0];
          state_d = CFG_RUN;
        end
        default: mask_d = wr_data[NUM_LVL-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CFG_RUN;
      base     <= '0;
      casc_cfg <= '0;
      mask     <= '1;
    end else begin
      state_q  <= state_d;
      base     <= base_d;
      casc_cfg <= casc_d;
      mask     <= mask_d;
    end
  end

  // R2: a data write during the sequence never touches the mask
  p_seq_keeps_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !init_clr && state_q != CFG_RUN) |=> $stable(mask));
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int NUM_LVL = 8,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready,
  input  logic [NUM_LVL-1:0] irr,
  input  logic [NUM_LVL-1:0] isr,
  input  logic [NUM_LVL-1:0] mask,
  output logic               int_req,
  output logic [LVL_W-1:0]   win_lvl
);
  logic [NUM_LVL-1:0] pend;
  logic               hp_ok, hs_ok;
  logic [LVL_W-1:0]   hp, hs;

  always_comb begin
    pend  = irr & ~mask;
    hp_ok = 1'b0;
    hp    = '0;
    hs_ok = 1'b0;
    hs    = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (pend[i]) begin
        hp_ok = 1'b1;
        hp    = LVL_W'(i);
      end
      if (isr[i]) begin
        hs_ok = 1'b1;
        hs    = LVL_W'(i);
      end
    end
    win_lvl = hp;
    int_req = ready && hp_ok && (!hs_ok || (hp < hs));
  end

  // R4: a masked level never wins
  p_win_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (!mask[win_lvl] && irr[win_lvl]));
  // R3: the winner is never already in service
  p_win_not_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> !isr[win_lvl]);
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int NUM_LVL = 8,
  parameter int VEC_W   = 8,
  localparam int LVL_W  = $clog2(NUM_LVL),
  localparam int BASE_W = VEC_W - LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               is_master,
  input  logic [NUM_LVL-1:0] irq_in,
  input  logic               inta,
  input  logic [LVL_W-1:0]   cas_in,
  input  logic               cas_valid_in,
  input  logic               init_clr,
  input  logic               eoi,
  input  logic               int_req,
  input  logic [LVL_W-1:0]   win_lvl,
  input  logic [BASE_W-1:0]  base,
  input  logic [NUM_LVL-1:0] casc_cfg,
  output logic [NUM_LVL-1:0] irr,
  output logic [NUM_LVL-1:0] isr,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  output logic [LVL_W-1:0]   cas_out,
  output logic               cas_valid_out
);
  logic [NUM_LVL-1:0] irq_prev, rise, win_bit, eoi_bit;
  logic [NUM_LVL-1:0] irr_d, isr_d;
  logic               take, to_slave, id_match;
  logic [VEC_W-1:0]   vec_d;
  logic [LVL_W-1:0]   cas_d;

  assign id_match = cas_valid_in && (cas_in == casc_cfg[LVL_W-1:0]);
  assign take     = int_req && (is_master ? inta : id_match);
  assign to_slave = is_master && casc_cfg[win_lvl];
  assign rise     = irq_in & ~irq_prev;
  assign win_bit  = take ? (NUM_LVL'(1) << win_lvl) : '0;
  assign eoi_bit  = eoi ? (isr & (~isr + NUM_LVL'(1))) : '0;

  always_comb begin
    if (init_clr) begin
      irr_d = '0;
      isr_d = '0;
    end else begin
      irr_d = (irr & ~win_bit) | rise;
      isr_d = (isr & ~eoi_bit) | win_bit;
    end
    vec_d = (take && !to_slave) ? {base, win_lvl} : vec_out;
    cas_d = (take && to_slave) ? win_lvl : cas_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev      <= '0;
      irr           <= '0;
      isr           <= '0;
      vec_out       <= '0;
      vec_valid     <= 1'b0;
      cas_out       <= '0;
      cas_valid_out <= 1'b0;
    end else begin
      irq_prev      <= irq_in;
      irr           <= irr_d;
      isr           <= isr_d;
      vec_out       <= vec_d;
      vec_valid     <= take && !to_slave && !init_clr;
      cas_out       <= cas_d;
      cas_valid_out <= take && to_slave && !init_clr;
    end
  end

  // R5: a vector always comes with some level in service
  p_vec_has_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (isr != '0));
  // R6: cascade output and vector never coincide, and only a master cascades
  p_vec_cas_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && cas_valid_out));
  p_cas_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid_out |-> is_master);
  // R8: end-of-interrupt retires exactly one in-service level
  p_eoi_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !take && !init_clr && isr != '0) |=>
      ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top #(
  parameter int NUM_LVL = 8,
  parameter int VEC_W   = 8,
  localparam int LVL_W  = $clog2(NUM_LVL),
  localparam int BASE_W = VEC_W - LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               is_master,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [VEC_W-1:0]   wr_data,
  input  logic [NUM_LVL-1:0] irq_in,
  input  logic               inta,
  input  logic [LVL_W-1:0]   cas_in,
  input  logic               cas_valid_in,
  output logic               int_out,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  output logic [LVL_W-1:0]   cas_out,
  output logic               cas_valid_out
);
  logic [1:0]         rst_pipe;
  logic               srst_n;
  logic [BASE_W-1:0]  base;
  logic [NUM_LVL-1:0] casc_cfg, mask, irr, isr;
  logic               ready, init_clr, eoi, int_req;
  logic [LVL_W-1:0]   win_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  pic_cfg #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) u_cfg (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .base(base), .casc_cfg(casc_cfg), .mask(mask),
    .ready(ready), .init_clr(init_clr), .eoi(eoi)
  );

  pic_prio #(.NUM_LVL(NUM_LVL)) u_prio (
    .clk(clk), .rst_n(srst_n), .ready(ready), .irr(irr), .isr(isr),
    .mask(mask), .int_req(int_req), .win_lvl(win_lvl)
  );

  pic_core #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) u_core (
    .clk(clk), .rst_n(srst_n), .is_master(is_master), .irq_in(irq_in),
    .inta(inta), .cas_in(cas_in), .cas_valid_in(cas_valid_in),
    .init_clr(init_clr), .eoi(eoi), .int_req(int_req), .win_lvl(win_lvl),
    .base(base), .casc_cfg(casc_cfg), .irr(irr), .isr(isr),
    .vec_out(vec_out), .vec_valid(vec_valid), .cas_out(cas_out),
    .cas_valid_out(cas_valid_out)
  );

  assign int_out = int_req;

  // R2: no request leaves the unit while configuration is incomplete
  p_int_ready_r2: assert property (@(posedge clk) disable iff (!srst_n)
    int_out |-> ready);
  // R9: an acknowledge with no request yields no response
  p_idle_ack_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (is_master && inta && !int_out) |=> (!vec_valid && !cas_valid_out));
endmodule

// File: tb/pic_cascade_top_bench.sv
`timescale 1ns/1ps
module pic_cascade_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_sel;
  logic [7:0] wr_data;
  logic       m_wr, s_wr, m_inta, s_inta, tb_cas_v;
  logic [2:0] tb_cas;
  logic [7:0] m_irq, s_irq;
  logic       m_int, m_vv, m_cv, s_int, s_vv, s_cv;
  logic [7:0] m_vec, s_vec;
  logic [2:0] m_cas, s_cas;
  logic [7:0] m_irq_bus;
  logic [2:0] s_cas_in;
  logic       s_cas_vin;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign m_irq_bus = {m_irq[7:4], s_int, m_irq[2:0]};
  assign s_cas_in  = tb_cas_v ? tb_cas : m_cas;
  assign s_cas_vin = tb_cas_v | m_cv;

  pic_cascade_top u_pic_cascade_top (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1), .wr_en(m_wr),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq_in(m_irq_bus), .inta(m_inta),
    .cas_in(3'd0), .cas_valid_in(1'b0), .int_out(m_int), .vec_out(m_vec),
    .vec_valid(m_vv), .cas_out(m_cas), .cas_valid_out(m_cv)
  );

  pic_cascade_top u_slave (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0), .wr_en(s_wr),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq_in(s_irq), .inta(s_inta),
    .cas_in(s_cas_in), .cas_valid_in(s_cas_vin), .int_out(s_int),
    .vec_out(s_vec), .vec_valid(s_vv), .cas_out(s_cas), .cas_valid_out(s_cv)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_m(input logic sel, input logic [7:0] d);
    m_wr = 1'b1; wr_sel = sel; wr_data = d; tick(); m_wr = 1'b0;
  endtask

  task automatic wr_s(input logic sel, input logic [7:0] d);
    s_wr = 1'b1; wr_sel = sel; wr_data = d; tick(); s_wr = 1'b0;
  endtask

  task automatic ack_m();
    m_inta = 1'b1; tick(); m_inta = 1'b0;
  endtask

  // Reference winner from the requirements: {valid, level}
  function automatic logic [3:0] f_win(input logic [7:0] irr, input logic [7:0] isr,
                                       input logic [7:0] imr);
    logic [7:0] p;
    int hp, hs;
    p = irr & ~imr; hp = 8; hs = 8;
    for (int i = 7; i >= 0; i--) begin
      if (p[i])   hp = i;
      if (isr[i]) hs = i;
    end
    if (hp < 8 && hp < hs) return {1'b1, 3'(hp)};
    return 4'd0;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] mi, ms, mm, nirq, d;
    logic [3:0] w;
    int unsigned op, b;
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_sel = 0; wr_data = 0; m_wr = 0; s_wr = 0;
    m_inta = 0; s_inta = 0; tb_cas_v = 0; tb_cas = 0; m_irq = 0; s_irq = 0;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R1 reset state and all-masked
    check("R1 int", {7'd0, m_int}, 8'd0);
    check("R1 vec_valid", {7'd0, m_vv}, 8'd0);
    check("R1 cas_valid", {7'd0, m_cv}, 8'd0);
    m_irq[1] = 1; tick(); m_irq[1] = 0;
    check("R1 masked after reset", {7'd0, m_int}, 8'd0);

    // R2 initialization sequence
    wr_m(0, 8'h10);
    m_irq[0] = 1; tick();
    check("R2 held during init", {7'd0, m_int}, 8'd0);
    wr_m(1, 8'h40);
    check("R2 held after base", {7'd0, m_int}, 8'd0);
    wr_m(1, 8'h08);
    check("R2 kept request after init", {7'd0, m_int}, 8'd1);
    ack_m();
    check("R5 vec_valid", {7'd0, m_vv}, 8'd1);
    check("R5 vector", m_vec, 8'h40);
    tick();
    check("R5 vec_valid one cycle", {7'd0, m_vv}, 8'd0);
    check("R5 pending cleared", {7'd0, m_int}, 8'd0);
    wr_m(0, 8'h20);
    m_irq[0] = 0; tick();

    wr_s(0, 8'h10); wr_s(1, 8'h88); wr_s(1, 8'h03);

    // R3 priority and nesting
    m_irq[5] = 1; m_irq[2] = 1; tick();
    check("R3 int", {7'd0, m_int}, 8'd1);
    ack_m();
    check("R3 highest wins", m_vec, 8'h42);
    check("R3 lower waits", {7'd0, m_int}, 8'd0);
    m_irq[1] = 1; tick();
    check("R3 preempt int", {7'd0, m_int}, 8'd1);
    ack_m();
    check("R3 preempt vector", m_vec, 8'h41);
    wr_m(0, 8'h20);
    check("R8 one level retired", {7'd0, m_int}, 8'd0);
    wr_m(0, 8'h20);
    check("R8 second retire", {7'd0, m_int}, 8'd1);
    ack_m();
    check("R3 last vector", m_vec, 8'h45);
    wr_m(0, 8'h20);
    m_irq = 0; tick();

    // R4 mask
    wr_m(1, 8'h04);
    m_irq[2] = 1; tick();
    check("R4 masked", {7'd0, m_int}, 8'd0);
    wr_m(1, 8'h00);
    check("R4 unmask keeps pending", {7'd0, m_int}, 8'd1);
    ack_m();
    check("R4 vector", m_vec, 8'h42);
    wr_m(0, 8'h20);
    m_irq = 0; tick();

    // R9 idle acknowledge
    ack_m();
    check("R9 no vector", {7'd0, m_vv}, 8'd0);
    check("R9 no cascade", {7'd0, m_cv}, 8'd0);

    // R8 ignored command byte
    m_irq[4] = 1; tick();
    ack_m();
    check("R8 setup vector", m_vec, 8'h44);
    wr_m(0, 8'h00);
    m_irq[6] = 1; tick();
    check("R8 null command ignored", {7'd0, m_int}, 8'd0);
    wr_m(0, 8'h20);
    check("R8 eoi frees level", {7'd0, m_int}, 8'd1);
    ack_m();
    check("R8 vector", m_vec, 8'h46);
    wr_m(0, 8'h20);
    m_irq = 0; tick();

    // R6 / R7 cascade
    s_irq[6] = 1; tick();
    check("R7 slave int", {7'd0, s_int}, 8'd1);
    tick();
    check("R6 master sees slave", {7'd0, m_int}, 8'd1);
    ack_m();
    check("R6 cas_valid", {7'd0, m_cv}, 8'd1);
    check("R6 cas_out", {5'd0, m_cas}, 8'd3);
    check("R6 no master vector", {7'd0, m_vv}, 8'd0);
    tick();
    check("R7 slave vec_valid", {7'd0, s_vv}, 8'd1);
    check("R7 slave vector", s_vec, 8'h8E);
    check("R6 cas one cycle", {7'd0, m_cv}, 8'd0);
    wr_s(0, 8'h20); wr_m(0, 8'h20);
    s_irq = 0; tick();

    // R7 foreign identity and stray acknowledge at slave
    s_irq[1] = 1; tick();
    tick();
    tb_cas_v = 1; tb_cas = 3'd5; tick(); tb_cas_v = 0;
    check("R7 foreign id ignored", {7'd0, s_vv}, 8'd0);
    s_inta = 1; tick(); s_inta = 0;
    check("R7 inta ignored", {7'd0, s_vv}, 8'd0);
    check("R7 still pending", {7'd0, s_int}, 8'd1);
    tb_cas_v = 1; tb_cas = 3'd3; tick(); tb_cas_v = 0;
    check("R7 own id vector", s_vec, 8'h89);
    check("R7 own id valid", {7'd0, s_vv}, 8'd1);
    ack_m();
    check("R6 cascade again", {7'd0, m_cv}, 8'd1);
    tick();
    check("R7 no pending, no answer", {7'd0, s_vv}, 8'd0);
    wr_m(0, 8'h20); wr_s(0, 8'h20);
    s_irq = 0; tick();

    // Random phase on master, level 3 masked
    mi = 0; ms = 0; mm = 8'h08; m_irq = 0;
    wr_m(1, 8'h08);
    for (int it = 0; it < 600; it++) begin
      op = $urandom % 8;
      w = f_win(mi, ms, mm);
      nirq = m_irq;
      if (op <= 2) begin
        b = $urandom % 8;
        if (b == 3) b = 7;
        nirq[b] = ~nirq[b];
        mi = mi | (nirq & ~m_irq);
        m_irq = nirq;
        tick();
      end else if (op == 3) begin
        d = 8'($urandom) | 8'h08;
        wr_m(1, d);
        mm = d;
      end else if (op <= 5) begin
        ack_m();
        check("R9 random valid", {7'd0, m_vv}, {7'd0, w[3]});
        if (w[3]) begin
          check("R5 random vector", m_vec, {5'b01000, w[2:0]});
          ms[w[2:0]] = 1'b1;
          mi[w[2:0]] = 1'b0;
        end
      end else if (op == 6) begin
        wr_m(0, 8'h20);
        ms = ms & ~(ms & (~ms + 8'd1));
      end else begin
        tick();
      end
      w = f_win(mi, ms, mm);
      check("R3 random int", {7'd0, m_int}, {7'd0, w[3]});
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule